// File: doc/BRIEF.md
# Dual-width byte-lane static memory

This block is a synthesizable stand-in for an asynchronous static RAM with a 16-bit common data bus. It is organized as a set of 16-bit rows. It can be read and written a whole row at a time, or one 8-bit lane at a time through two byte-lane selects. A width-mode input switches it into an 8-bit organization. In that mode the memory holds twice as many 8-bit words, and the top data pin stops carrying data and becomes the least significant address bit.

The bidirectional bus is split into `dq_in`, `dq_out` and one drive enable per 8-bit lane. Data sits on `dq_in`, `dq_out` and `dq_oe` combinationally, as on the asynchronous part. The storage array is clocked. A level-sensitive write is turned into a commit on the first clock edge at which the write condition is no longer met. The data, row and lanes that were present in the last active cycle are committed. A read in that same cycle already returns the new data. Electrical levels, power and analog timing are not modelled.

Top module: `dual_width_sram`

## Requirements
- R1: The device is selected only when `cs_n` is 0 and `cs` is 1. When it is not selected, `dq_oe` is 2'b00, `dq_out` is zero and no write takes place.
- R2: In 16-bit mode (`x8_n` = 1), a selected cycle with both `lb_n` and `ub_n` at 1 is standby: `dq_oe` is 2'b00 and nothing is written.
- R3: A 16-bit read is a selected cycle with `we_n` = 1 and `oe_n` = 0. It drives `dq_oe` = {~`ub_n`, ~`lb_n`}. Bit 0 covers `dq_out[7:0]` and bit 1 covers `dq_out[15:8]`. Each driven lane carries the stored byte of row `addr`: the lower lane holds bits 7:0 and the upper lane holds bits 15:8. Every lane that is not driven reads as zero.
- R4: A selected cycle with `we_n` = 0 is a write whatever the value of `oe_n`. During a write, `dq_oe` is 2'b00.
- R5: A selected cycle with both `we_n` and `oe_n` at 1 is output-disable: `dq_oe` is 2'b00 and nothing is written.
- R6: In 8-bit mode (`x8_n` = 0, with `lb_n` = `ub_n` = 0), data moves only on `dq_in[7:0]` and `dq_out[7:0]`. `dq_oe[1]` stays 0 and `dq_out[15:8]` is zero. `dq_in[15]` acts as address bit A-1: 0 selects bits 7:0 of row `addr` and 1 selects bits 15:8.
- R7: A write changes only its enabled lanes. In 16-bit mode these are the lanes whose byte select is 0. In 8-bit mode only the half chosen by A-1 changes. All other stored bytes keep their values.
- R8: A write lasts while select, `we_n` = 0 and an enabled lane all hold. Its row, lanes and data are those of its last active cycle. Releasing any of these conditions ends the write, and the new data is returned by a read in the first cycle after the write ends.
- R9: When the device is selected in 8-bit mode with `lb_n` or `ub_n` at 1, `illegal_cfg` is 1, `dq_oe` is 2'b00 and nothing is written. Otherwise `illegal_cfg` is 0.
- R10: With `rst_n` = 0 sampled on a clock edge (synchronous, active low), a write that is still pending is abandoned and the stored data keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the internal storage array |
| rst_n | input | 1 | Synchronous active-low reset of the write tracking |
| cs_n | input | 1 | Active-low chip select |
| cs | input | 1 | Active-high chip select |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| lb_n | input | 1 | Active-low lower lane select (bits 7:0) |
| ub_n | input | 1 | Active-low upper lane select (bits 15:8) |
| x8_n | input | 1 | Width mode: 0 selects 8-bit, 1 selects 16-bit |
| addr | input | ROW_AW | Row address |
| dq_in | input | 16 | Incoming data bus value; bit 15 is A-1 in 8-bit mode |
| dq_out | output | 16 | Outgoing data, zero on lanes that are not driven |
| dq_oe | output | 2 | Drive enable per lane: bit 0 for 7:0, bit 1 for 15:8 |
| illegal_cfg | output | 1 | 8-bit mode requested without both lane selects low |

## Verification
The bench builds the block with ROW_AW = 4, which gives 16 rows. At that size every row can be loaded with a known pattern, and the first and last rows can be reached in both organizations, including the last byte of 8-bit space. At this depth, rows whose address differs in the top bit are distinct, so a fault in the row decode shows up as wrong read data. The default of 8 keeps elaboration small. The full 1M-row organization needs only ROW_AW = 20.

// File: rtl/dws_pkg.sv
// Shared types for the dual-width static memory.
// Assumes: the bus is 16 bits wide, split into two 8-bit lanes.
package dws_pkg;

    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int BUS_W  = LANES * LANE_W;

    typedef enum logic [2:0] {
        CY_STANDBY,
        CY_ILLEGAL,
        CY_DISABLE,
        CY_READ,
        CY_WRITE
    } cycle_e;

    typedef struct packed {
        cycle_e           kind;
        logic             byte_mode;
        logic [LANES-1:0] lanes;
        logic             half;
    } access_t;

endpackage

// File: rtl/dws_decode.sv
// Pin decoder: classifies each cycle and picks the lanes it touches.
// Assumes: all control pins are active as documented in the brief.
// In byte mode the lane is chosen by A-1, which arrives on the top data pin.
module dws_decode
    import dws_pkg::*;
(
    input  logic    cs_n,
    input  logic    cs,
    input  logic    we_n,
    input  logic    oe_n,
    input  logic    lb_n,
    input  logic    ub_n,
    input  logic    x8_n,
    input  logic    a_m1,
    output access_t acc,
    output logic    illegal
);

    logic selected;
    logic byte_mode;
    logic no_lane;

    // Basic select, mode and lane conditions.
    always_comb begin
        selected  = !cs_n && cs;
        byte_mode = !x8_n;
        no_lane   = lb_n && ub_n;
        illegal   = selected && byte_mode && (lb_n || ub_n);
    end

    // Cycle classification with standby taking priority over operation.
    always_comb begin
        acc.byte_mode = byte_mode;
        acc.half      = a_m1;
        if (byte_mode) begin
            acc.lanes = a_m1 ? 2'b10 : 2'b01;
        end else begin
            acc.lanes = {!ub_n, !lb_n};
        end
        if (!selected) begin
            acc.kind = CY_STANDBY;
        end else if (illegal) begin
            acc.kind = CY_ILLEGAL;
        end else if (!byte_mode && no_lane) begin
            acc.kind = CY_STANDBY;
        end else if (!we_n) begin
            acc.kind = CY_WRITE;
        end else if (!oe_n) begin
            acc.kind = CY_READ;
        end else begin
            acc.kind = CY_DISABLE;
        end
    end

endmodule

// File: rtl/dws_write_ctl.sv
// Write tracker: turns the level-sensitive write into a clocked commit.
// It captures row, lanes and data on every active cycle. It signals a
// commit in the first cycle where the write condition is gone.
// Assumes: synchronous active-low reset; reset abandons a pending write.
module dws_write_ctl
    import dws_pkg::*;
#(
    parameter int ROW_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_active,
    input  logic [ROW_AW-1:0] row,
    input  logic [LANES-1:0]  lanes,
    input  logic [BUS_W-1:0]  wdata,
    output logic              commit,
    output logic [ROW_AW-1:0] c_row,
    output logic [LANES-1:0]  c_lanes,
    output logic [BUS_W-1:0]  c_data
);

    logic act_q;

    // Remember whether the previous cycle was inside a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
        end else begin
            act_q <= wr_active;
        end
    end

    // Hold the latest row, lanes and data seen while the write is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_row   <= '0;
            c_lanes <= '0;
            c_data  <= '0;
        end else if (wr_active) begin
            c_row   <= row;
            c_lanes <= lanes;
            c_data  <= wdata;
        end
    end

    // A commit is due once the condition falls, never while in reset.
    always_comb begin
        commit = rst_n && act_q && !wr_active;
    end

endmodule

// File: rtl/dws_array.sv
// Storage array: one byte-wide memory per lane with a write port and an
// asynchronous read port. The read port forwards the data of a commit
// that is due in the current cycle.
// Assumes: the contents are not reset, as on a real static RAM.
module dws_array
    import dws_pkg::*;
#(
    parameter int ROW_AW = 8
) (
    input  logic              clk,
    input  logic              commit,
    input  logic [ROW_AW-1:0] w_row,
    input  logic [LANES-1:0]  w_lanes,
    input  logic [BUS_W-1:0]  w_data,
    input  logic [ROW_AW-1:0] rd_row,
    output logic [BUS_W-1:0]  rd_data
);

    localparam int ROWS = 1 << ROW_AW;

    logic fwd_row_hit;

    // A forward can only apply to the row being committed.
    always_comb begin
        fwd_row_hit = commit && (w_row == rd_row);
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [ROWS];
        logic [LANE_W-1:0] stored;
        logic [LANE_W-1:0] wbyte;

        // Split the write data and read the stored byte of this lane.
        always_comb begin
            wbyte  = w_data[l*LANE_W +: LANE_W];
            stored = mem[rd_row];
        end

        // Commit the byte when this lane is enabled.
        always_ff @(posedge clk) begin
            if (commit && w_lanes[l]) begin
                mem[w_row] <= wbyte;
            end
        end

        // Read result, taken from the commit when it targets this lane.
        always_comb begin
            if (fwd_row_hit && w_lanes[l]) begin
                rd_data[l*LANE_W +: LANE_W] = wbyte;
            end else begin
                rd_data[l*LANE_W +: LANE_W] = stored;
            end
        end
    end

endmodule

// File: rtl/dws_read_fmt.sv
// Read formatter: places row data on the lanes and drives the enables.
// In byte mode the chosen half goes to the low lane and the high lane stays off.
// Assumes: lanes that are not driven show zero on dq_out.
module dws_read_fmt
    import dws_pkg::*;
(
    input  access_t          acc,
    input  logic [BUS_W-1:0] rd_data,
    output logic [BUS_W-1:0] dq_out,
    output logic [LANES-1:0] dq_oe
);

    logic [LANE_W-1:0] half_byte;

    // Pick the half addressed by A-1 for byte-mode reads.
    always_comb begin
        half_byte = acc.half ? rd_data[BUS_W-1 -: LANE_W] : rd_data[LANE_W-1:0];
    end

    // Drive data and enables for reads only.
    always_comb begin
        dq_out = '0;
        dq_oe  = '0;
        if (acc.kind == CY_READ) begin
            if (acc.byte_mode) begin
                dq_out[LANE_W-1:0] = half_byte;
                dq_oe              = 2'b01;
            end else begin
                for (int l = 0; l < LANES; l++) begin
                    if (acc.lanes[l]) begin
                        dq_out[l*LANE_W +: LANE_W] = rd_data[l*LANE_W +: LANE_W];
                    end
                end
                dq_oe = acc.lanes;
            end
        end
    end

endmodule

// File: rtl/dual_width_sram.sv
// Dual-width static memory. It works as 2**ROW_AW rows of 16 bits, or as
// twice as many bytes when x8_n is low, with the top data pin then used
// as the least significant address bit.
// Assumes: inputs settle between clock edges; the clock only drives the
// internal array commit.
module dual_width_sram
    import dws_pkg::*;
#(
    parameter int ROW_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              cs,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              lb_n,
    input  logic              ub_n,
    input  logic              x8_n,
    input  logic [ROW_AW-1:0] addr,
    input  logic [BUS_W-1:0]  dq_in,
    output logic [BUS_W-1:0]  dq_out,
    output logic [LANES-1:0]  dq_oe,
    output logic              illegal_cfg
);

    access_t           acc;
    logic              wr_active;
    logic [BUS_W-1:0]  wdata;
    logic              commit;
    logic [ROW_AW-1:0] c_row;
    logic [LANES-1:0]  c_lanes;
    logic [BUS_W-1:0]  c_data;
    logic [BUS_W-1:0]  rd_data;

    dws_decode u_decode (
        .cs_n    (cs_n),
        .cs      (cs),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .lb_n    (lb_n),
        .ub_n    (ub_n),
        .x8_n    (x8_n),
        .a_m1    (dq_in[BUS_W-1]),
        .acc     (acc),
        .illegal (illegal_cfg)
    );

    // Write condition and lane placement of the incoming data.
    always_comb begin
        wr_active = (acc.kind == CY_WRITE);
        if (acc.byte_mode) begin
            wdata = {dq_in[LANE_W-1:0], dq_in[LANE_W-1:0]};
        end else begin
            wdata = dq_in;
        end
    end

    dws_write_ctl #(.ROW_AW(ROW_AW)) u_wctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_active (wr_active),
        .row       (addr),
        .lanes     (acc.lanes),
        .wdata     (wdata),
        .commit    (commit),
        .c_row     (c_row),
        .c_lanes   (c_lanes),
        .c_data    (c_data)
    );

    dws_array #(.ROW_AW(ROW_AW)) u_array (
        .clk     (clk),
        .commit  (commit),
        .w_row   (c_row),
        .w_lanes (c_lanes),
        .w_data  (c_data),
        .rd_row  (addr),
        .rd_data (rd_data)
    );

    dws_read_fmt u_rfmt (
        .acc     (acc),
        .rd_data (rd_data),
        .dq_out  (dq_out),
        .dq_oe   (dq_oe)
    );

endmodule

// File: rtl/dws_checker.sv
// Checker for the dual-width static memory, bound to every instance.
// It relates the pin decode to the bus drive enables and the error flag.
module dws_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        cs,
    input logic        we_n,
    input logic        oe_n,
    input logic        lb_n,
    input logic        ub_n,
    input logic        x8_n,
    input logic [15:0] dq_out,
    input logic [1:0]  dq_oe,
    input logic        illegal_cfg
);

    logic sel;
    logic word_ok;

    // Helper terms taken from the pins only.
    always_comb begin
        sel     = !cs_n && cs;
        word_ok = sel && x8_n && !(lb_n && ub_n);
    end

    a_r1_deselect_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (dq_oe == 2'b00 && dq_out == 16'h0000));

    a_r2_no_lane_standby: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && x8_n && lb_n && ub_n) |-> dq_oe == 2'b00);

    a_r3_word_read_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ok && we_n && !oe_n) |-> dq_oe == {!ub_n, !lb_n});

    a_r3_idle_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe[0] |-> dq_out[7:0] == 8'h00);

    a_r4_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !we_n) |-> dq_oe == 2'b00);

    a_r5_out_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && we_n && oe_n) |-> dq_oe == 2'b00);

    a_r6_byte_high_off: assert property (@(posedge clk) disable iff (!rst_n)
        !x8_n |-> (!dq_oe[1] && dq_out[15:8] == 8'h00));

    a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_cfg |-> (dq_oe == 2'b00 && sel && !x8_n));

endmodule

bind dual_width_sram dws_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .cs          (cs),
    .we_n        (we_n),
    .oe_n        (oe_n),
    .lb_n        (lb_n),
    .ub_n        (ub_n),
    .x8_n        (x8_n),
    .dq_out      (dq_out),
    .dq_oe       (dq_oe),
    .illegal_cfg (illegal_cfg)
);

// File: tb/dual_width_sram_tb_top.sv
`timescale 1ns/1ps
module dual_width_sram_tb_top;

    localparam int AW   = 4;
    localparam int ROWS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, cs = 1'b0, we_n = 1'b1, oe_n = 1'b1;
    logic          lb_n = 1'b1, ub_n = 1'b1, x8_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   dq_in = '0;
    logic [15:0]   dq_out;
    logic [1:0]    dq_oe;
    logic          illegal_cfg;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    // Reference model state
    logic [7:0] m_lo [ROWS];
    logic [7:0] m_hi [ROWS];
    bit         prev_act = 0;
    int         p_row;
    bit [1:0]   p_lanes;
    bit [15:0]  p_data;

    always #2.5 clk = ~clk;

    dual_width_sram #(.ROW_AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs(cs), .we_n(we_n),
        .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n), .x8_n(x8_n), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .illegal_cfg(illegal_cfg)
    );

    // One cycle: drive pins, update the model, compare, then let the edge pass.
    task automatic cyc(input string tag, input bit rn, input bit csn, input bit cs1,
                       input bit wen, input bit oen, input bit lbn, input bit ubn,
                       input bit x8n, input int row, input bit [15:0] din);
        bit sel, bm, ill, ok, act, rd;
        bit [1:0]  lanes, e_oe;
        bit [15:0] e_out;
        @(negedge clk);
        rst_n = rn; cs_n = csn; cs = cs1; we_n = wen; oe_n = oen;
        lb_n = lbn; ub_n = ubn; x8_n = x8n; addr = row[AW-1:0]; dq_in = din;
        #1;
        sel   = !csn && cs1;
        bm    = !x8n;
        ill   = sel && bm && (lbn || ubn);
        ok    = sel && !ill && !(!bm && lbn && ubn);
        act   = ok && !wen;
        rd    = ok && wen && !oen;
        lanes = bm ? (din[15] ? 2'b10 : 2'b01) : {!ubn, !lbn};
        if (rn && prev_act && !act) begin
            if (p_lanes[0]) m_lo[p_row] = p_data[7:0];
            if (p_lanes[1]) m_hi[p_row] = p_data[15:8];
        end
        e_oe  = 2'b00;
        e_out = 16'h0000;
        if (rd) begin
            if (bm) begin
                e_oe  = 2'b01;
                e_out = {8'h00, din[15] ? m_hi[row] : m_lo[row]};
            end else begin
                e_oe  = lanes;
                e_out = {lanes[1] ? m_hi[row] : 8'h00, lanes[0] ? m_lo[row] : 8'h00};
            end
        end
        n_cmp++;
        if (dq_oe !== e_oe || dq_out !== e_out || illegal_cfg !== ill) begin
            n_bad++;
            $display("FAIL %s: oe=%b exp %b out=%h exp %h ill=%b exp %b",
                     tag, dq_oe, e_oe, dq_out, e_out, illegal_cfg, ill);
        end
        if (act) begin
            p_row   = row;
            p_lanes = lanes;
            p_data  = bm ? {din[7:0], din[7:0]} : din;
        end
        prev_act = rn && act;
    endtask

    // Shorthands: word write, word read, deselected idle.
    task automatic wwr(input string tag, input int row, input bit [15:0] d,
                       input bit lbn, input bit ubn);
        cyc(tag, 1, 0, 1, 0, 1, lbn, ubn, 1, row, d);
    endtask
    task automatic wrd(input string tag, input int row, input bit lbn, input bit ubn);
        cyc(tag, 1, 0, 1, 1, 0, lbn, ubn, 1, row, 16'h0);
    endtask
    task automatic idle(input string tag);
        cyc(tag, 1, 1, 0, 1, 1, 1, 1, 1, 0, 16'h0);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        // Reset state (R1, R9): nothing driven, flag low.
        cyc("R1 reset", 0, 1, 0, 1, 1, 1, 1, 1, 0, 16'h0);
        cyc("R1 reset", 0, 1, 0, 1, 1, 1, 1, 1, 0, 16'h0);
        idle("R1 idle");

        // Load every row with a full word (R4 with oe_n low as well, R8 commit).
        for (int r = 0; r < ROWS; r++) begin
            cyc("R4 write oe low", 1, 0, 1, 0, r[0], 0, 0, 1, r, 16'hA050 + 16'(r * 16'h0101));
            idle("R8 end by deselect");
        end
        for (int r = 0; r < ROWS; r++) wrd("R3 word read", r, 0, 0);

        // Lane reads (R3).
        wrd("R3 lower only", 3, 0, 1);
        wrd("R3 upper only", 3, 1, 0);
        wrd("R3 last row", ROWS - 1, 0, 0);

        // Standby with both lanes off, even while writing (R2).
        cyc("R2 no lane read", 1, 0, 1, 1, 0, 1, 1, 1, 5, 16'h0);
        cyc("R2 no lane write", 1, 0, 1, 0, 1, 1, 1, 1, 5, 16'hDEAD);
        wrd("R2 row untouched", 5, 0, 0);

        // Deselect by either chip select (R1); write attempt must not land.
        cyc("R1 cs_n high", 1, 1, 1, 0, 0, 0, 0, 1, 6, 16'h1111);
        cyc("R1 cs low", 1, 0, 0, 0, 0, 0, 0, 1, 6, 16'h2222);
        wrd("R1 row untouched", 6, 0, 0);

        // Output disable (R5).
        cyc("R5 out disable", 1, 0, 1, 1, 1, 0, 0, 1, 2, 16'h0);
        wrd("R5 row intact", 2, 0, 0);

        // Lane-masked word writes (R7).
        wwr("R7 lower write", 7, 16'h1234, 0, 1);
        idle("R7 end");
        wwr("R7 upper write", 8, 16'h5678, 1, 0);
        idle("R7 end");
        wrd("R7 lower only changed", 7, 0, 0);
        wrd("R7 upper only changed", 8, 0, 0);

        // Byte mode writes and reads, both halves, edge rows (R6, R7).
        cyc("R6 byte wr lo", 1, 0, 1, 0, 1, 0, 0, 0, 0, 16'h00C3);
        idle("R6 end");
        cyc("R6 byte wr hi", 1, 0, 1, 0, 1, 0, 0, 0, ROWS - 1, 16'h803C);
        idle("R6 end");
        cyc("R6 byte rd lo", 1, 0, 1, 1, 0, 0, 0, 0, 0, 16'h0000);
        cyc("R6 byte rd hi", 1, 0, 1, 1, 0, 0, 0, 0, 0, 16'h8000);
        cyc("R6 byte rd last", 1, 0, 1, 1, 0, 0, 0, 0, ROWS - 1, 16'h8000);
        cyc("R6 byte rd last lo", 1, 0, 1, 1, 0, 0, 0, 0, ROWS - 1, 16'h0000);
        wrd("R7 byte half kept", 0, 0, 0);
        wrd("R7 byte half kept", ROWS - 1, 0, 0);

        // Illegal byte configuration (R9).
        cyc("R9 illegal lb", 1, 0, 1, 0, 0, 1, 0, 0, 9, 16'h00EE);
        cyc("R9 illegal ub", 1, 0, 1, 1, 0, 0, 1, 0, 9, 16'h00EE);
        idle("R9 clear");
        wrd("R9 row untouched", 9, 0, 0);

        // Write ending by lane release, last data wins, read in the end cycle (R8).
        wwr("R8 write a", 10, 16'h0F0F, 0, 0);
        wwr("R8 write b", 10, 16'hF00F, 0, 0);
        wrd("R8 read at end", 10, 0, 0);
        wwr("R8 write c", 11, 16'hBEEF, 0, 0);
        cyc("R8 end by lanes", 1, 0, 1, 0, 1, 1, 1, 1, 11, 16'h0);
        wrd("R8 read after lane end", 11, 0, 0);
        wwr("R8 write d", 12, 16'hCAFE, 0, 0);
        cyc("R8 end by we", 1, 0, 1, 1, 0, 0, 0, 1, 12, 16'h0);
        wrd("R8 read again", 12, 0, 0);
        wwr("R8 write e", 13, 16'h7777, 0, 0);
        cyc("R8 end by cs", 1, 0, 0, 0, 1, 0, 0, 1, 13, 16'h7777);
        wrd("R8 read after cs end", 13, 0, 0);

        // Reset abandons a pending write (R10).
        wwr("R10 write", 14, 16'h9999, 0, 0);
        cyc("R10 reset", 0, 1, 0, 1, 1, 1, 1, 1, 14, 16'h0);
        idle("R10 out of reset");
        wrd("R10 row kept", 14, 0, 0);

        idle("end");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule